// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the burst and latency engine of a four-bank synchronous DRAM. Each clock edge it samples a decoded command (no-op, mode load, read, write or stop), a bank index, a starting column and a mode word. A mode load updates a stored set of burst options. A read or write starts a burst: the block steps through the column addresses of that burst, one per cycle, and reports the bank the burst belongs to. For reads it also raises a data-valid strobe, with the column it belongs to, a programmable number of cycles after each address beat.

A burst ends after its programmed length. It also ends early when a stop command arrives, or when a new read or write replaces it at once. Full-page bursts run until they are stopped or replaced, wrapping inside the 256-column page. Read beats already issued before a stop or replacement still reach the data-valid output.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is low, and after reset until the first read or write, col_valid_o, col_we_o and rd_valid_o are 0. The mode after reset is burst length 1, sequential order, read latency 2.
- R2: A mode load (cmd_i = 3'b001) stores mode_i[2:0] as the length code (000 = 1, 001 = 2, 010 = 4, 011 = 8, 111 = full page), mode_i[3] as the order (0 = sequential, 1 = interleaved) and mode_i[6:4] as the latency code (010 = 2, 011 = 3). A length or latency code outside these sets leaves that field unchanged, while the other fields still load.
- R3: In a sequential burst of length N, beat k addresses the column whose low log2(N) bits are (start + k) mod N and whose upper bits equal those of the start column.
- R4: In an interleaved burst of length N, beat k addresses the column whose low log2(N) bits are the start's low bits XOR k, with the upper bits kept.
- R5: A full-page burst addresses (start + k) mod 256 whatever the order bit says, and keeps going past 256 beats until a stop or a new burst.
- R6: A write (cmd_i = 3'b011) shows its first column, with col_we_o = 1, in the cycle right after the edge that samples it, and col_we_o stays 1 on every beat of the write.
- R7: For a read (cmd_i = 3'b010), rd_valid_o and rd_col_o repeat the read's col_valid_o/col_o beats exactly L cycles later, L being the programmed latency. Write beats never raise rd_valid_o.
- R8: A stop (cmd_i = 3'b100) clears col_valid_o from the next cycle on. Read beats issued before it still appear on rd_valid_o L cycles after they were issued.
- R9: A read or write during a burst drops the old burst. From the next cycle the new start column and bank are shown, and the bank stays fixed for the rest of that burst.
- R10: Bursts of length 1, 2, 4 and 8 show exactly that many beats, then col_valid_o returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Command: 000 no-op, 001 mode load, 010 read, 011 write, 100 stop |
| bank_i | input | 2 | Bank index of a read or write |
| col_i | input | 8 | Starting column of a read or write |
| mode_i | input | 7 | Mode word, used on a mode load |
| col_valid_o | output | 1 | A burst beat is being addressed this cycle |
| col_we_o | output | 1 | The current beat belongs to a write |
| bank_o | output | 2 | Bank of the current burst |
| col_o | output | 8 | Column of the current beat |
| rd_valid_o | output | 1 | Read data-valid strobe, delayed by the read latency |
| rd_col_o | output | 8 | Column the delayed read strobe belongs to |

## Verification
Sequential and interleaved bursts start from the same unaligned columns (0x15 and 0x2D). At those offsets the two orders give different sequences, so a swapped or miscomputed order shows up. The same read is issued at latency 2 and at latency 3, which separates the two delay taps. A full-page write that starts at 0xFE crosses the page wrap and runs past 256 beats with the order bit set, which exposes a wrong wrap or an early end. A stopped read, a read replaced by a write and a mode load with illegal codes show which beats survive an early end and which fields a bad code may change.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
// Shared command codes, mode-register layout and code checks for the
// burst column sequencer. Assumes the command is already decoded.
package sdram_seq_pkg;

    localparam logic [2:0] CMD_NOP   = 3'b000;
    localparam logic [2:0] CMD_MODE  = 3'b001;
    localparam logic [2:0] CMD_READ  = 3'b010;
    localparam logic [2:0] CMD_WRITE = 3'b011;
    localparam logic [2:0] CMD_STOP  = 3'b100;

    localparam logic [2:0] LEN_FULL  = 3'b111;

    typedef struct packed {
        logic [2:0] lat_code;    // read latency, low two bits give the cycle count
        logic       interleave;  // 1 = interleaved order
        logic [2:0] len_code;    // burst length code
    } mode_t;

    localparam mode_t MODE_RESET = '{lat_code: 3'b010, interleave: 1'b0, len_code: 3'b000};

    // True for the length codes the sequencer accepts.
    function automatic logic len_code_ok(input logic [2:0] code);
        return (code == 3'b000) || (code == 3'b001) || (code == 3'b010)
            || (code == 3'b011) || (code == LEN_FULL);
    endfunction

    // True for the latency codes the sequencer accepts.
    function automatic logic lat_code_ok(input logic [2:0] code);
        return (code == 3'b010) || (code == 3'b011);
    endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
`timescale 1ns/1ps
// Mode register. On a load it takes each field on its own; a length or
// latency code it does not recognise leaves that field as it was.
// Assumes load_i is a single-cycle decoded strobe.
module sdram_mode_reg
    import sdram_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  mode_t mode_i,
    output mode_t mode_o
);

    // Field-wise update of the stored burst options.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= MODE_RESET;
        end else if (load_i) begin
            if (len_code_ok(mode_i.len_code)) begin
                mode_o.len_code <= mode_i.len_code;
            end
            mode_o.interleave <= mode_i.interleave;
            if (lat_code_ok(mode_i.lat_code)) begin
                mode_o.lat_code <= mode_i.lat_code;
            end
        end
    end

endmodule

// File: rtl/sdram_burst_ctr.sv
`timescale 1ns/1ps
// Burst state: captures start column, bank, direction and burst options
// when a read or write arrives, counts beats, and ends the burst on its
// last beat, on a stop, or replaces it on a new read/write.
// Assumes mode options are taken once per burst, at its start.
module sdram_burst_ctr
    import sdram_seq_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    localparam int KW    = $clog2(COL_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [2:0]        len_code_i,
    input  logic              interleave_i,
    output logic              active_o,
    output logic              write_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [COL_W-1:0]  base_o,
    output logic [COL_W-1:0]  beat_o,
    output logic [KW-1:0]     bits_o,
    output logic              inter_o
);

    localparam logic [KW-1:0] FULL_BITS = KW'(COL_W);

    logic [KW-1:0]    bits_new;
    logic [COL_W-1:0] last_beat;
    logic             full_page;

    // Number of counting column bits for the requested length code.
    always_comb begin
        case (len_code_i)
            3'b000:  bits_new = KW'(0);
            3'b001:  bits_new = KW'(1);
            3'b010:  bits_new = KW'(2);
            3'b011:  bits_new = KW'(3);
            default: bits_new = FULL_BITS;
        endcase
    end

    // Index of the final beat and full-page flag for the running burst.
    always_comb begin
        last_beat = ~({COL_W{1'b1}} << bits_o);
        full_page = (bits_o == FULL_BITS);
    end

    // Start, advance, finish or cut short the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            write_o  <= 1'b0;
            bank_o   <= '0;
            base_o   <= '0;
            beat_o   <= '0;
            bits_o   <= '0;
            inter_o  <= 1'b0;
        end else if (cmd_i == CMD_READ || cmd_i == CMD_WRITE) begin
            active_o <= 1'b1;
            write_o  <= (cmd_i == CMD_WRITE);
            bank_o   <= bank_i;
            base_o   <= col_i;
            beat_o   <= '0;
            bits_o   <= bits_new;
            inter_o  <= interleave_i && (len_code_i != LEN_FULL);
        end else if (cmd_i == CMD_STOP) begin
            active_o <= 1'b0;
        end else if (active_o) begin
            if (!full_page && beat_o == last_beat) begin
                active_o <= 1'b0;
            end
            beat_o <= beat_o + 1'b1;
        end
    end

endmodule

// File: rtl/sdram_col_gen.sv
`timescale 1ns/1ps
// Column address of the current beat. The low bits_i bits of the start
// column either count up with wrap (sequential) or are XORed with the beat
// number (interleaved); the bits above stay as in the start column.
// Assumes beat_i stays below 2**bits_i except in full-page mode.
module sdram_col_gen #(
    parameter int COL_W = 8,
    localparam int KW   = $clog2(COL_W + 1)
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [KW-1:0]    bits_i,
    input  logic             inter_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] low_mask;
    logic [COL_W-1:0] low_part;

    // Merge the fixed upper bits with the ordered low bits.
    always_comb begin
        low_mask = ~({COL_W{1'b1}} << bits_i);
        low_part = inter_i ? (base_i ^ beat_i) : (base_i + beat_i);
        col_o    = (base_i & ~low_mask) | (low_part & low_mask);
    end

endmodule

// File: rtl/sdram_rd_pipe.sv
`timescale 1ns/1ps
// Read strobe delay line. Every cycle the current read beat (valid flag and
// column) enters stage 0 and moves one stage per clock; the output tap is
// chosen by the programmed latency. Assumes lat_i is 2 or 3 and only
// changes while no read is in flight.
module sdram_rd_pipe #(
    parameter int COL_W   = 8,
    parameter int MAX_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [1:0]       lat_i,
    output logic             valid_o,
    output logic [COL_W-1:0] col_o
);

    logic [MAX_LAT-1:0]       tap_v;
    logic [MAX_LAT*COL_W-1:0] tap_c;
    logic [1:0]               tap_idx;

    for (genvar i = 0; i < MAX_LAT; i++) begin : g_stage
        logic             v_d;
        logic [COL_W-1:0] c_d;
        if (i == 0) begin : g_head
            assign v_d = valid_i;
            assign c_d = col_i;
        end else begin : g_tail
            assign v_d = tap_v[i-1];
            assign c_d = tap_c[(i-1)*COL_W +: COL_W];
        end
        // One delay stage of the read strobe and its column.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tap_v[i]                 <= 1'b0;
                tap_c[i*COL_W +: COL_W]  <= '0;
            end else begin
                tap_v[i]                 <= v_d;
                tap_c[i*COL_W +: COL_W]  <= c_d;
            end
        end
    end

    // Select the stage matching the latency: stage L-1 is L cycles late.
    always_comb begin
        tap_idx = lat_i - 2'd1;
        valid_o = tap_v[tap_idx];
        col_o   = tap_c[tap_idx*COL_W +: COL_W];
    end

endmodule

// File: rtl/sdram_burst_seq.sv
`timescale 1ns/1ps
// Burst column sequencer top. Ties together the mode register, burst
// counter, column generator and read strobe delay line. Assumes decoded
// commands, one per cycle, and a single burst stream shared by all banks.
module sdram_burst_seq
    import sdram_seq_pkg::*;
#(
    parameter int COL_W   = 8,
    parameter int BANK_W  = 2,
    parameter int MAX_LAT = 3,
    localparam int MODE_W = $bits(mode_t),
    localparam int KW     = $clog2(COL_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              col_valid_o,
    output logic              col_we_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [COL_W-1:0]  col_o,
    output logic              rd_valid_o,
    output logic [COL_W-1:0]  rd_col_o
);

    mode_t            mode_q;
    logic             active;
    logic             is_write;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] beat;
    logic [KW-1:0]    bits;
    logic             inter;

    sdram_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cmd_i == CMD_MODE),
        .mode_i (mode_t'(mode_i)),
        .mode_o (mode_q)
    );

    sdram_burst_ctr #(
        .COL_W  (COL_W),
        .BANK_W (BANK_W)
    ) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd_i),
        .bank_i       (bank_i),
        .col_i        (col_i),
        .len_code_i   (mode_q.len_code),
        .interleave_i (mode_q.interleave),
        .active_o     (active),
        .write_o      (is_write),
        .bank_o       (bank_o),
        .base_o       (base),
        .beat_o       (beat),
        .bits_o       (bits),
        .inter_o      (inter)
    );

    sdram_col_gen #(
        .COL_W (COL_W)
    ) u_col (
        .base_i  (base),
        .beat_i  (beat),
        .bits_i  (bits),
        .inter_i (inter),
        .col_o   (col_o)
    );

    sdram_rd_pipe #(
        .COL_W   (COL_W),
        .MAX_LAT (MAX_LAT)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (active && !is_write),
        .col_i   (col_o),
        .lat_i   (mode_q.lat_code[1:0]),
        .valid_o (rd_valid_o),
        .col_o   (rd_col_o)
    );

    // Beat flags seen at the port.
    always_comb begin
        col_valid_o = active;
        col_we_o    = active && is_write;
    end

endmodule

// File: rtl/sdram_burst_seq_chk.sv
`timescale 1ns/1ps
// Port-level checker for the burst column sequencer, bound to the top.
// Assumes the default latency range of 2 to 3 cycles.
module sdram_burst_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd_i,
    input logic [BANK_W-1:0] bank_i,
    input logic [COL_W-1:0]  col_i,
    input logic              col_valid_o,
    input logic              col_we_o,
    input logic [BANK_W-1:0] bank_o,
    input logic [COL_W-1:0]  col_o,
    input logic              rd_valid_o,
    input logic [COL_W-1:0]  rd_col_o
);

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!col_valid_o && !col_we_o && !rd_valid_o));

    p_we_in_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        col_we_o |-> col_valid_o);

    p_rd_delayed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |->
            (($past(col_valid_o && !col_we_o, 2) && $past(col_o, 2) == rd_col_o)
          || ($past(col_valid_o && !col_we_o, 3) && $past(col_o, 3) == rd_col_o)));

    p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_STOP) |=> !col_valid_o);

    p_new_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_READ || cmd_i == CMD_WRITE) |=>
            (col_valid_o && col_o == $past(col_i) && bank_o == $past(bank_i)
             && col_we_o == ($past(cmd_i) == CMD_WRITE)));

    p_bank_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && cmd_i == CMD_NOP) |=> (!col_valid_o || $stable(bank_o)));

endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(
    .COL_W  (COL_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .bank_i      (bank_i),
    .col_i       (col_i),
    .col_valid_o (col_valid_o),
    .col_we_o    (col_we_o),
    .bank_o      (bank_o),
    .col_o       (col_o),
    .rd_valid_o  (rd_valid_o),
    .rd_col_o    (rd_col_o)
);

// File: tb/sdram_burst_seq_test.sv
`timescale 1ns/1ps
// Directed bench for the burst column sequencer: one task per scenario.
module sdram_burst_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = 3'b000;
    logic [1:0] bank = 2'd0;
    logic [7:0] col = 8'h00;
    logic [6:0] mode = 7'h00;
    logic       col_valid, col_we, rd_valid;
    logic [1:0] bank_out;
    logic [7:0] col_out, rd_col;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] exp_q [8];

    always #2.5 clk = ~clk;

    sdram_burst_seq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .bank_i      (bank),
        .col_i       (col),
        .mode_i      (mode),
        .col_valid_o (col_valid),
        .col_we_o    (col_we),
        .bank_o      (bank_out),
        .col_o       (col_out),
        .rd_valid_o  (rd_valid),
        .rd_col_o    (rd_col)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Mode word: [6:4] latency code, [3] interleave, [2:0] length code.
    task automatic load_mode(input logic [2:0] len, input logic il, input logic [2:0] lat);
        cmd  = 3'b001;
        mode = {lat, il, len};
        tick();
        cmd  = 3'b000;
    endtask

    task automatic start(input logic wr, input logic [1:0] b, input logic [7:0] c);
        cmd  = wr ? 3'b011 : 3'b010;
        bank = b;
        col  = c;
        tick();
        cmd  = 3'b000;
    endtask

    task automatic set_exp(input logic [7:0] a0, a1, a2, a3, a4, a5, a6, a7);
        exp_q = '{a0, a1, a2, a3, a4, a5, a6, a7};
    endtask

    // Issue a burst and check every beat and every delayed read strobe.
    task automatic run_burst(input string req, input logic wr, input logic [1:0] b,
                             input logic [7:0] c, input int n, input int lat);
        start(wr, b, c);
        for (int k = 0; k <= n + lat; k++) begin
            chk(req, "col_valid", col_valid, (k < n));
            if (k < n) begin
                chk(req, "col", col_out, exp_q[k]);
                chk(req, "we", col_we, wr);
                chk(req, "bank", bank_out, b);
            end
            if (!wr) begin
                chk(req, "rd_valid", rd_valid, (k >= lat && k < lat + n));
                if (k >= lat && k < lat + n) chk(req, "rd_col", rd_col, exp_q[k-lat]);
            end else begin
                chk(req, "rd_valid on write", rd_valid, 1'b0);
            end
            tick();
        end
    endtask

    task automatic t_reset();
        cmd = 3'b010;
        repeat (3) tick();
        chk("R1", "col_valid in reset", col_valid, 1'b0);
        chk("R1", "we in reset", col_we, 1'b0);
        chk("R1", "rd_valid in reset", rd_valid, 1'b0);
        cmd = 3'b000;
        rst_n = 1'b1;
        tick();
        chk("R1", "col_valid after reset", col_valid, 1'b0);
        set_exp(8'h40, 0, 0, 0, 0, 0, 0, 0);
        run_burst("R1 default BL1 CL2", 1'b0, 2'd0, 8'h40, 1, 2);
    endtask

    task automatic t_sequential();
        load_mode(3'b010, 1'b0, 3'b010);
        set_exp(8'h15, 8'h16, 8'h17, 8'h14, 0, 0, 0, 0);
        run_burst("R3 R6 R10 seq BL4 write", 1'b1, 2'd1, 8'h15, 4, 0);
        load_mode(3'b011, 1'b0, 3'b010);
        set_exp(8'h2D, 8'h2E, 8'h2F, 8'h28, 8'h29, 8'h2A, 8'h2B, 8'h2C);
        run_burst("R3 R10 seq BL8 write", 1'b1, 2'd2, 8'h2D, 8, 0);
        load_mode(3'b001, 1'b0, 3'b010);
        set_exp(8'h15, 8'h14, 0, 0, 0, 0, 0, 0);
        run_burst("R3 R10 seq BL2 read", 1'b0, 2'd3, 8'h15, 2, 2);
    endtask

    task automatic t_interleave();
        load_mode(3'b010, 1'b1, 3'b010);
        set_exp(8'h15, 8'h14, 8'h17, 8'h16, 0, 0, 0, 0);
        run_burst("R4 interleave BL4", 1'b1, 2'd0, 8'h15, 4, 0);
        load_mode(3'b011, 1'b1, 3'b010);
        set_exp(8'h2D, 8'h2C, 8'h2F, 8'h2E, 8'h29, 8'h28, 8'h2B, 8'h2A);
        run_burst("R4 interleave BL8", 1'b1, 2'd1, 8'h2D, 8, 0);
    endtask

    task automatic t_latency();
        load_mode(3'b010, 1'b0, 3'b011);
        set_exp(8'h15, 8'h16, 8'h17, 8'h14, 0, 0, 0, 0);
        run_burst("R7 read CL3", 1'b0, 2'd2, 8'h15, 4, 3);
        load_mode(3'b010, 1'b0, 3'b010);
        run_burst("R7 read CL2", 1'b0, 2'd2, 8'h15, 4, 2);
    endtask

    task automatic t_bad_mode();
        load_mode(3'b001, 1'b0, 3'b010);
        load_mode(3'b101, 1'b1, 3'b001);
        set_exp(8'h15, 8'h14, 0, 0, 0, 0, 0, 0);
        run_burst("R2 illegal codes kept, order loaded", 1'b0, 2'd1, 8'h15, 2, 2);
    endtask

    task automatic t_full_page();
        load_mode(3'b111, 1'b1, 3'b010);
        start(1'b1, 2'd3, 8'hFE);
        for (int k = 0; k < 260; k++) begin
            chk("R5", "full page valid", col_valid, 1'b1);
            chk("R5", "full page col", col_out, 8'((8'hFE + k) % 256));
            tick();
        end
        cmd = 3'b100;
        tick();
        cmd = 3'b000;
        chk("R8", "full page stopped", col_valid, 1'b0);
        tick();
        chk("R8", "full page stays stopped", col_valid, 1'b0);
    endtask

    task automatic t_stop_read();
        load_mode(3'b011, 1'b0, 3'b011);
        start(1'b0, 2'd3, 8'h20);
        for (int k = 0; k < 3; k++) begin
            chk("R8", "beat before stop", col_out, 8'h20 + 8'(k));
            if (k < 2) tick();
        end
        cmd = 3'b100;
        tick();
        cmd = 3'b000;
        for (int k = 3; k < 7; k++) begin
            chk("R8", "no beat after stop", col_valid, 1'b0);
            chk("R8", "issued reads delivered", rd_valid, (k < 6));
            if (k < 6) chk("R8", "delivered column", rd_col, 8'h20 + 8'(k - 3));
            tick();
        end
    endtask

    task automatic t_interrupt();
        load_mode(3'b011, 1'b0, 3'b010);
        start(1'b0, 2'd1, 8'h10);
        chk("R9", "read beat 0", col_out, 8'h10);
        tick();
        chk("R9", "read beat 1", col_out, 8'h11);
        cmd  = 3'b011;
        bank = 2'd2;
        col  = 8'h80;
        tick();
        cmd  = 3'b000;
        for (int k = 2; k <= 10; k++) begin
            chk("R9", "valid", col_valid, (k < 10));
            if (k < 10) begin
                chk("R9", "new column", col_out, 8'h80 + 8'(k - 2));
                chk("R9", "new bank", bank_out, 2'd2);
                chk("R9", "write flag", col_we, 1'b1);
            end
            chk("R7 R9", "old read strobes", rd_valid, (k < 4));
            if (k < 4) chk("R7 R9", "old read column", rd_col, 8'h10 + 8'(k - 2));
            tick();
        end
    endtask

    initial begin
        #1;
        t_reset();
        t_sequential();
        t_interleave();
        t_latency();
        t_bad_mode();
        t_full_page();
        t_stop_read();
        t_interrupt();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule